// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Evaluator

This block performs the four 32-bit integer operations of a small register-register instruction set (add, subtract, bitwise AND, bitwise XOR) and keeps three condition flags: zero, sign and overflow. The result is combinational and is meant to be written back to the destination register by the surrounding datapath. The flags are registered and change only on a clock edge where the caller asks for an update.

A branch evaluator reads the registered flags and answers, for a given jump code, whether a conditional jump is taken. Address arithmetic, such as moving a stack pointer, can reuse the add operation with the flag update held low, so the flags from the last real arithmetic operation survive.

Operand naming follows the instruction format. `src_a` is the first register field and `dst_b` is the second. Subtract yields `dst_b - src_a`. Any unsupported operation code or jump code raises an error output. On that cycle the flags do not change.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `src_a + dst_b` modulo 2^32 in the same cycle.
- R2: With `alu_fn` = 1, `result` equals `dst_b - src_a` modulo 2^32 in the same cycle.
- R3: On a flag update, overflow is set for add when the signed sum lies outside [-2^31, 2^31-1]. For subtract it is set when the signed difference `dst_b - src_a` lies outside that range.
- R4: With `alu_fn` = 2, `result` is the bitwise AND. With `alu_fn` = 3, it is the bitwise XOR. A flag update from either operation clears overflow.
- R5: On a flag update, zero is set exactly when `result` is 0, and sign equals bit 31 of `result`.
- R6: The flags load on the rising clock edge only when `flag_we` is 1 and `fn_err` is 0. Otherwise they keep their value.
- R7: A synchronous reset with `rst_n` low sets zero=1, sign=0 and overflow=0.
- R8: `take_branch` depends on `jmp_fn` and the registered flags, with L = sign xor overflow:
  - 0: always 1
  - 1: L or zero
  - 2: L
  - 3: zero
  - 4: not zero
  - 5: not L
  - 6: not (L or zero)
- R9: When `alu_fn` is 4 or above, or `jmp_fn` is 7 or above, `fn_err` is 1 and the flags do not change. An invalid `alu_fn` gives a `result` of 0. An invalid `jmp_fn` gives a `take_branch` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a | input | 32 | First operand (source register field) |
| dst_b | input | 32 | Second operand (destination register field) |
| alu_fn | input | 4 | Operation code: 0 add, 1 subtract, 2 AND, 3 XOR |
| flag_we | input | 1 | Request to load the flags from this operation |
| jmp_fn | input | 4 | Jump condition code, 0 to 6 |
| result | output | 32 | Operation result |
| zf_q | output | 1 | Registered zero flag |
| sf_q | output | 1 | Registered sign flag |
| of_q | output | 1 | Registered overflow flag |
| take_branch | output | 1 | Selected jump condition holds |
| fn_err | output | 1 | Unsupported operation or jump code |

## Verification
Directed operands probe the signed limits:
- the largest positive plus one;
- the most negative minus one;
- equal operands in a subtraction.

These separate correct overflow detection from plain carry detection, and they show the subtract operand order. Many random operand pairs, operation codes and enable values then run against a signed-integer model. Each jump code is evaluated after flag states produced by real operations, so every condition is checked against both outcomes. Invalid codes are sent with the enable high, which shows that the error path blocks the flag write and does not merely report it.

// File: rtl/alu_cc_pkg.sv
// Package: shared widths, operation and jump codes, and the flag record
// for the ALU / condition-code block. Assumes a two's-complement datapath.
package alu_cc_pkg;

    localparam int DATA_W = 32;
    localparam int FN_W   = 4;

    // Operation codes on the ALU function input
    localparam logic [FN_W-1:0] OP_ADD = 4'd0;
    localparam logic [FN_W-1:0] OP_SUB = 4'd1;
    localparam logic [FN_W-1:0] OP_AND = 4'd2;
    localparam logic [FN_W-1:0] OP_XOR = 4'd3;
    localparam int              OP_CNT = 4;

    // Jump condition codes
    localparam logic [FN_W-1:0] JC_ALW = 4'd0;
    localparam logic [FN_W-1:0] JC_LE  = 4'd1;
    localparam logic [FN_W-1:0] JC_LT  = 4'd2;
    localparam logic [FN_W-1:0] JC_EQ  = 4'd3;
    localparam logic [FN_W-1:0] JC_NE  = 4'd4;
    localparam logic [FN_W-1:0] JC_GE  = 4'd5;
    localparam logic [FN_W-1:0] JC_GT  = 4'd6;
    localparam int              JC_CNT = 7;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_flags_t;

    localparam cc_flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_datapath.sv
// Module: combinational arithmetic/logic unit.
// Computes add, subtract (b - a), AND and XOR on W-bit operands.
// Also produces the flag values the operation would load.
// Assumes the caller decides whether those flags are actually stored.
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int FNW = FN_W
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [FNW-1:0] fn,
    output logic [W-1:0]   res,
    output logic           fn_ok,
    output cc_flags_t      nxt_flags
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum_v;
    logic [W-1:0] dif_v;
    logic         sum_ovf;
    logic         dif_ovf;
    logic         ovf_sel;

    // Adder and subtractor run side by side; the select picks one
    always_comb begin
        sum_v   = opb + opa;
        dif_v   = opb - opa;
        sum_ovf = (opa[MSB] == opb[MSB]) && (sum_v[MSB] != opa[MSB]);
        dif_ovf = (opa[MSB] != opb[MSB]) && (dif_v[MSB] != opb[MSB]);
    end

    // Result and overflow select by operation code
    always_comb begin
        fn_ok   = 1'b1;
        ovf_sel = 1'b0;
        res     = '0;
        case (fn)
            OP_ADD: begin res = sum_v;     ovf_sel = sum_ovf; end
            OP_SUB: begin res = dif_v;     ovf_sel = dif_ovf; end
            OP_AND: begin res = opa & opb; ovf_sel = 1'b0;    end
            OP_XOR: begin res = opa ^ opb; ovf_sel = 1'b0;    end
            default: fn_ok = 1'b0;
        endcase
    end

    // Candidate flag values derived from the selected result
    always_comb begin
        nxt_flags.zf = (res == '0);
        nxt_flags.sf = res[MSB];
        nxt_flags.of = ovf_sel;
    end

endmodule

// File: rtl/alu_cc_flag_reg.sv
// Module: three-bit condition-code register.
// Loads the candidate flags when load is high.
// Resets synchronously (active low) to zero=1, sign=0, overflow=0.
module alu_cc_flag_reg
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t d,
    output cc_flags_t q
);

    // Flag storage with synchronous reset and load enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= FLAGS_RST;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/alu_cc_cond_eval.sv
// Module: jump-condition evaluator.
// Maps a jump code and the stored flags to a taken bit.
// Assumes codes 0..6 are defined; any other code gives not-taken and code_ok=0.
module alu_cc_cond_eval
    import alu_cc_pkg::*;
#(
    parameter int FNW = FN_W
) (
    input  cc_flags_t      flags,
    input  logic [FNW-1:0] code,
    output logic           taken,
    output logic           code_ok
);

    logic lt_c;
    logic le_c;

    // Signed less-than and less-or-equal from the flag set
    always_comb begin
        lt_c = flags.sf ^ flags.of;
        le_c = lt_c | flags.zf;
    end

    // Condition select
    always_comb begin
        code_ok = 1'b1;
        taken   = 1'b0;
        case (code)
            JC_ALW: taken = 1'b1;
            JC_LE:  taken = le_c;
            JC_LT:  taken = lt_c;
            JC_EQ:  taken = flags.zf;
            JC_NE:  taken = ~flags.zf;
            JC_GE:  taken = ~lt_c;
            JC_GT:  taken = ~le_c;
            default: code_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_cc_unit.sv
// Module: top of the ALU with condition flags and branch evaluator.
// Result is combinational; flags are registered and load only when
// flag_we is high and both codes are valid. take_branch uses stored flags.
module alu_cc_unit
    import alu_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] dst_b,
    input  logic [FN_W-1:0]   alu_fn,
    input  logic              flag_we,
    input  logic [FN_W-1:0]   jmp_fn,
    output logic [DATA_W-1:0] result,
    output logic              zf_q,
    output logic              sf_q,
    output logic              of_q,
    output logic              take_branch,
    output logic              fn_err
);

    cc_flags_t nxt_flags;
    cc_flags_t cur_flags;
    logic      alu_ok;
    logic      jmp_ok;
    logic      flag_load;

    alu_cc_datapath #(.W(DATA_W), .FNW(FN_W)) u_dp (
        .opa       (src_a),
        .opb       (dst_b),
        .fn        (alu_fn),
        .res       (result),
        .fn_ok     (alu_ok),
        .nxt_flags (nxt_flags)
    );

    // Error decode and gated flag load
    always_comb begin
        fn_err    = ~alu_ok | ~jmp_ok;
        flag_load = flag_we & ~fn_err;
    end

    alu_cc_flag_reg u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (nxt_flags),
        .q     (cur_flags)
    );

    alu_cc_cond_eval #(.FNW(FN_W)) u_jc (
        .flags   (cur_flags),
        .code    (jmp_fn),
        .taken   (take_branch),
        .code_ok (jmp_ok)
    );

    // Flag outputs
    always_comb begin
        zf_q = cur_flags.zf;
        sf_q = cur_flags.sf;
        of_q = cur_flags.of;
    end

endmodule

// File: rtl/alu_cc_unit_chk.sv
// Checker for alu_cc_unit: temporal properties on the top-level ports.
module alu_cc_unit_chk
    import alu_cc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] result,
    input logic [FN_W-1:0]   alu_fn,
    input logic              flag_we,
    input logic [FN_W-1:0]   jmp_fn,
    input logic              zf_q,
    input logic              sf_q,
    input logic              of_q,
    input logic              take_branch,
    input logic              fn_err
);

    // R7: reset value of the flags
    p_reset_flags_r7: assert property (@(posedge clk)
        !rst_n |=> (zf_q && !sf_q && !of_q));

    // R6: no update request keeps the flags
    p_hold_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> ($stable(zf_q) && $stable(sf_q) && $stable(of_q)));

    // R9: an error blocks the flag load
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fn_err |=> ($stable(zf_q) && $stable(sf_q) && $stable(of_q)));

    // R5: zero and sign follow the result that was loaded
    p_zero_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !fn_err) |=>
            (zf_q == ($past(result) == '0)) && (sf_q == $past(result[DATA_W-1])));

    // R4: logic operations clear overflow
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !fn_err && (alu_fn == OP_AND || alu_fn == OP_XOR)) |=> !of_q);

    // R8: the unconditional code always takes, equal and not-equal follow zero
    p_jmp_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_fn == JC_ALW) |-> take_branch);
    p_jmp_eq_ne_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((jmp_fn == JC_EQ) |-> (take_branch == zf_q)) and
        ((jmp_fn == JC_NE) |-> (take_branch == !zf_q)));

    // R9: an invalid jump code never reports taken
    p_bad_jmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_fn >= 4'd7) |-> (fn_err && !take_branch));

endmodule

bind alu_cc_unit alu_cc_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .result      (result),
    .alu_fn      (alu_fn),
    .flag_we     (flag_we),
    .jmp_fn      (jmp_fn),
    .zf_q        (zf_q),
    .sf_q        (sf_q),
    .of_q        (of_q),
    .take_branch (take_branch),
    .fn_err      (fn_err)
);

// File: tb/alu_cc_unit_tb_top.sv
// Bench: behavioural reference model (signed integers) compared every cycle.
module alu_cc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] dst_b = '0;
    logic [3:0]  alu_fn = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  jmp_fn = '0;
    logic [31:0] result;
    logic        zf_q, sf_q, of_q, take_branch, fn_err;

    int checks = 0;
    int errors = 0;

    // model flags and the tag describing how they were last produced
    bit    m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;
    string flag_tag = "R7";

    alu_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .dst_b(dst_b),
        .alu_fn(alu_fn), .flag_we(flag_we), .jmp_fn(jmp_fn),
        .result(result), .zf_q(zf_q), .sf_q(sf_q), .of_q(of_q),
        .take_branch(take_branch), .fn_err(fn_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_flags();
        chk(flag_tag, "zero flag", zf_q, m_zf);
        chk(flag_tag, "sign flag", sf_q, m_sf);
        chk(flag_tag == "R5" ? "R3" : flag_tag, "overflow flag", of_q, m_of);
    endtask

    // one operation: drive at negedge, check comb outputs, update model after posedge
    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input int op, input bit we, input int jf);
        longint sa, sb, s;
        logic [31:0] exp_r;
        bit e_of, e_err, lt, le, e_take;
        string rtag;
        @(negedge clk);
        src_a = a; dst_b = b; alu_fn = op[3:0]; flag_we = we; jmp_fn = jf[3:0];
        #2;
        chk_flags();
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e_of = 0;
        case (op)
            0: begin s = sa + sb; exp_r = s[31:0]; rtag = "R1";
                     e_of = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            1: begin s = sb - sa; exp_r = s[31:0]; rtag = "R2";
                     e_of = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            2: begin exp_r = a & b; rtag = "R4"; end
            3: begin exp_r = a ^ b; rtag = "R4"; end
            default: begin exp_r = 32'd0; rtag = "R9"; end
        endcase
        e_err = (op >= 4) || (jf >= 7);
        lt = m_sf ^ m_of;
        le = lt | m_zf;
        case (jf)
            0: e_take = 1; 1: e_take = le; 2: e_take = lt; 3: e_take = m_zf;
            4: e_take = !m_zf; 5: e_take = !lt; 6: e_take = !le;
            default: e_take = 0;
        endcase
        chk(rtag, "result", result, exp_r);
        chk("R9", "error output", fn_err, e_err);
        chk(jf >= 7 ? "R9" : "R8", "take_branch", take_branch, e_take);
        @(posedge clk);
        if (we && !e_err) begin
            m_zf = (exp_r == 0); m_sf = exp_r[31]; m_of = e_of;
            flag_tag = "R5";
        end else begin
            flag_tag = e_err ? "R9" : "R6";
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R7", "reset zero", zf_q, 1);
        chk("R7", "reset sign", sf_q, 0);
        chk("R7", "reset overflow", of_q, 0);
        // R1/R3: positive overflow on add
        step(32'h0000_0001, 32'h7FFF_FFFF, 0, 1, 2);
        // R2/R3: b - a crossing the negative limit
        step(32'h0000_0001, 32'h8000_0000, 1, 1, 1);
        // R2/R5: equal operands give zero
        step(32'h1234_5678, 32'h1234_5678, 1, 1, 3);
        // R6: add without update keeps zero set
        step(32'h0000_0004, 32'h0000_0100, 0, 0, 3);
        step(32'h0000_0004, 32'h0000_0100, 0, 0, 4);
        // R4: logic ops, overflow cleared
        step(32'hF0F0_0000, 32'hFF00_FF00, 2, 1, 6);
        step(32'hFFFF_FFFF, 32'h0000_0001, 3, 1, 5);
        // R9: invalid op and invalid jump with update requested
        step(32'h0000_0001, 32'h7FFF_FFFF, 5, 1, 0);
        step(32'h0000_0001, 32'h7FFF_FFFF, 0, 1, 7);
        step(32'h0, 32'h0, 15, 1, 15);
        // R8: all jump codes after a negative result without overflow
        step(32'h0000_0005, 32'h0000_0003, 1, 1, 0);
        for (int j = 0; j < 7; j++) step(32'h0, 32'h0, 0, 0, j);
        // R8: all jump codes after a positive result
        step(32'h0000_0003, 32'h0000_0005, 1, 1, 0);
        for (int j = 0; j < 7; j++) step(32'h0, 32'h0, 0, 0, j);
        // random sweep
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb;
            int sel;
            sel = $urandom_range(0, 3);
            ra = $urandom();
            rb = (sel == 0) ? ra : $urandom();
            if (sel == 1) ra = {ra[31], 31'h7FFF_FFF0 | ra[3:0]};
            step(ra, rb, ($urandom_range(0, 19) == 0) ? $urandom_range(4, 15) : $urandom_range(0, 3),
                 $urandom_range(0, 3) != 0,
                 ($urandom_range(0, 19) == 0) ? $urandom_range(7, 15) : $urandom_range(0, 6));
        end
        @(negedge clk);
        #2;
        chk_flags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule